// File: doc/BRIEF.md
# Serial Flash Write-Control Unit

This block owns the status register of a serial NOR flash slave and decides whether each state-changing instruction may run. A serial front end hands it decoded events: an opcode strobe at the end of the first byte of a transaction, a strobe for each later complete byte with its value, and a strobe when chip select returns high, along with the number of clock pulses beyond the last full byte. The block also watches the write-protect pin and a completion pulse from the timer that runs the array operations.

Write-status, program and erase requests are judged when chip select rises. An accepted request raises the busy flag, keeps the write-enable latch set, and issues a one-cycle start pulse with an operation kind and the captured start address. The array timer later pulses done, which clears both busy and the write-enable latch. For status reads the block offers a status snapshot that is refreshed at the read opcode and again at every further byte, so a host polling in one long transaction sees the busy flag fall.

Top module: `flash_wr_ctrl`

## Requirements
- R1: After reset the status byte is 00h, `wip` is 0 and `op_start` is 0.
- R2: Status byte layout: bit 0 busy, bit 1 write-enable latch, bits 2..4 protect field (bit 2 lowest), bits 5 and 6 always 0, bit 7 status lock. Opcode 06h sets the latch and 04h clears it, each acting on its opcode strobe.
- R3: Write-status (01h), program (02h), sector erase (20h or D7h), block erase (D8h) and chip erase (C7h or 60h) are ignored when the latch is 0.
- R4: An accepted write-status copies data bits 7 and 4..2 of the first byte after the opcode into the lock bit and protect field; busy and latch bits are not written. With the lock bit 1 and `wp_n` low, write-status is ignored.
- R5: While busy is 1, every opcode other than status read (05h) is ignored, including 06h and 04h.
- R6: A write command is discarded when `bit_rem` is not 0 at the chip-select rise.
- R7: A write command starts only at the chip-select rise, and only after enough bytes: 2 for write-status, 4 for erase, 5 for program, 1 for chip erase. `op_start` pulses in the cycle after the rise with `op_kind` 0 write-status, 1 program, 2 sector, 3 block, 4 chip, and busy reads 1 from then on.
- R8: Chip erase is accepted only when the protect field is 000b.
- R9: Program, sector and block erase are rejected when the start address lies in the protected region. Protect field 000b protects nothing; 001b the top quarter (address top two bits 11b); 010b the top half (top bit 1); 011b and any value with bit 2 set protect everything. The start address is the three bytes after the opcode, first byte most significant, low `ADDR_W` bits used, and appears on `op_addr` with `op_start`.
- R10: A done pulse while busy clears busy and the latch in the next cycle.
- R11: `status_out` is loaded with the status at the status-read opcode and reloaded at each later byte of that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Opcode byte complete strobe |
| cmd_op | input | 8 | Opcode value |
| byte_valid | input | 1 | Later byte complete strobe |
| byte_in | input | 8 | Later byte value |
| cs_rise | input | 1 | Chip select went high |
| bit_rem | input | 3 | Clock pulses past the last full byte at the rise |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Array operation finished pulse |
| op_start | output | 1 | Start pulse for an accepted write |
| op_kind | output | 3 | Kind of the started operation |
| op_addr | output | ADDR_W | Start address of the operation |
| wip | output | 1 | Busy flag |
| status_out | output | 8 | Status snapshot for the shifter |

## Verification
A wrong latch, busy or protect bit shows up the next time a status read is issued, one cycle after its opcode strobe, and also as a missing or extra `op_start` pulse one cycle after the following chip-select rise. Because the protect field gates acceptance by address, a corrupted field shows up as a program or erase that is accepted or rejected against the expected region. A snapshot that is not refreshed shows as a stale busy bit one cycle after the next byte strobe of a long status read.

// File: rtl/flash_wr_pkg.sv
`timescale 1ns/1ps
package flash_wr_pkg;
  localparam logic [7:0] OPC_NONE = 8'h00;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_SE_A = 8'h20;
  localparam logic [7:0] OPC_SE_B = 8'hD7;
  localparam logic [7:0] OPC_BE   = 8'hD8;
  localparam logic [7:0] OPC_CE_A = 8'hC7;
  localparam logic [7:0] OPC_CE_B = 8'h60;

  localparam int ADDR_BYTES = 3;
  localparam int NB_SR      = 2;
  localparam int NB_ERASE   = 1 + ADDR_BYTES;
  localparam int NB_PROG    = 2 + ADDR_BYTES;
  localparam int CNT_W      = $clog2(NB_PROG + 1);

  typedef enum logic [2:0] {
    KIND_SR   = 3'd0,
    KIND_PROG = 3'd1,
    KIND_SECT = 3'd2,
    KIND_BLK  = 3'd3,
    KIND_CHIP = 3'd4
  } wr_kind_e;

  function automatic logic region_locked(input logic [2:0] bp, input logic [1:0] top);
    logic hit;
    if (bp[2]) hit = 1'b1;
    else begin
      case (bp[1:0])
        2'd0:    hit = 1'b0;
        2'd1:    hit = (top == 2'b11);
        2'd2:    hit = top[1];
        default: hit = 1'b1;
      endcase
    end
    return hit;
  endfunction
endpackage

// File: rtl/wrc_cmd_track.sv
`timescale 1ns/1ps
module wrc_cmd_track
  import flash_wr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  input  logic              cs_rise,
  input  logic              busy,
  output logic [7:0]        op_q,
  output logic [CNT_W-1:0]  nbytes_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              srwd_new_q,
  output logic [2:0]        bp_new_q
);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(NB_PROG);

  logic [7:0]        op_d;
  logic [CNT_W-1:0]  cnt_d;
  logic [ADDR_W-1:0] addr_d;
  logic              srwd_d;
  logic [2:0]        bp_d;

  always_comb begin
    op_d   = op_q;
    cnt_d  = nbytes_q;
    addr_d = addr_q;
    srwd_d = srwd_new_q;
    bp_d   = bp_new_q;
    if (cs_rise) begin
      op_d  = OPC_NONE;
      cnt_d = '0;
    end else if (cmd_valid) begin
      op_d  = (busy && (cmd_op != OPC_RDSR)) ? OPC_NONE : cmd_op;
      cnt_d = CNT_ONE;
    end else if (byte_valid && (nbytes_q != '0)) begin
      if (nbytes_q <= CNT_ADDR) addr_d = ADDR_W'({addr_q, byte_in});
      if (nbytes_q == CNT_ONE) begin
        srwd_d = byte_in[7];
        bp_d   = byte_in[4:2];
      end
      if (nbytes_q != CNT_MAX) cnt_d = nbytes_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OPC_NONE;
      nbytes_q   <= '0;
      addr_q     <= '0;
      srwd_new_q <= 1'b0;
      bp_new_q   <= '0;
    end else begin
      op_q       <= op_d;
      nbytes_q   <= cnt_d;
      addr_q     <= addr_d;
      srwd_new_q <= srwd_d;
      bp_new_q   <= bp_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    nbytes_q <= CNT_MAX) else $error("byte count out of range"); // R7
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && cmd_op != OPC_RDSR && !cs_rise) |=> (op_q == OPC_NONE))
    else $error("opcode latched while busy"); // R5
endmodule

// File: rtl/wrc_gate.sv
`timescale 1ns/1ps
module wrc_gate
  import flash_wr_pkg::*;
(
  input  logic             cs_rise,
  input  logic [2:0]       bit_rem,
  input  logic [7:0]       op,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [1:0]       addr_top,
  input  logic             wp_n,
  input  logic             wel,
  input  logic             wip,
  input  logic [2:0]       bp,
  input  logic             srwd,
  output logic             accept,
  output logic             sr_write,
  output wr_kind_e         kind
);
  localparam logic [CNT_W-1:0] NEED_SR    = CNT_W'(NB_SR);
  localparam logic [CNT_W-1:0] NEED_ERASE = CNT_W'(NB_ERASE);
  localparam logic [CNT_W-1:0] NEED_PROG  = CNT_W'(NB_PROG);

  logic req_ok;
  logic locked;
  logic sr_locked;

  assign req_ok    = cs_rise && (bit_rem == 3'd0) && wel && !wip;
  assign locked    = region_locked(bp, addr_top);
  assign sr_locked = srwd && !wp_n;

  always_comb begin
    accept   = 1'b0;
    sr_write = 1'b0;
    kind     = KIND_SR;
    case (op)
      OPC_WRSR: begin
        kind     = KIND_SR;
        accept   = req_ok && (nbytes >= NEED_SR) && !sr_locked;
        sr_write = accept;
      end
      OPC_PROG: begin
        kind   = KIND_PROG;
        accept = req_ok && (nbytes >= NEED_PROG) && !locked;
      end
      OPC_SE_A, OPC_SE_B: begin
        kind   = KIND_SECT;
        accept = req_ok && (nbytes >= NEED_ERASE) && !locked;
      end
      OPC_BE: begin
        kind   = KIND_BLK;
        accept = req_ok && (nbytes >= NEED_ERASE) && !locked;
      end
      OPC_CE_A, OPC_CE_B: begin
        kind   = KIND_CHIP;
        accept = req_ok && (bp == 3'd0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wrc_status.sv
`timescale 1ns/1ps
module wrc_status
  import flash_wr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic              byte_valid,
  input  logic [7:0]        op_q,
  input  logic              wp_n,
  input  logic              accept,
  input  logic              sr_write,
  input  wr_kind_e          kind,
  input  logic              srwd_new,
  input  logic [2:0]        bp_new,
  input  logic [ADDR_W-1:0] addr,
  input  logic              op_done,
  output logic              wip_q,
  output logic              wel_q,
  output logic [2:0]        bp_q,
  output logic              srwd_q,
  output logic [7:0]        snap_q,
  output logic              start_q,
  output logic [2:0]        kind_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic       wip_d, wel_d;
  logic       snap_en;
  logic [7:0] status_now;

  assign status_now = {srwd_q, 2'b00, bp_q, wel_q, wip_q};
  assign snap_en    = (cmd_valid && cmd_op == OPC_RDSR) ||
                      (byte_valid && op_q == OPC_RDSR);

  always_comb begin
    wip_d = wip_q;
    if (accept) wip_d = 1'b1;
    else if (op_done) wip_d = 1'b0;
  end

  always_comb begin
    wel_d = wel_q;
    if (op_done && wip_q) wel_d = 1'b0;
    else if (cmd_valid && !wip_q) begin
      if (cmd_op == OPC_WREN) wel_d = 1'b1;
      else if (cmd_op == OPC_WRDI) wel_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q   <= 1'b0;
      wel_q   <= 1'b0;
      bp_q    <= '0;
      srwd_q  <= 1'b0;
      snap_q  <= '0;
      start_q <= 1'b0;
      kind_q  <= '0;
      addr_q  <= '0;
    end else begin
      wip_q   <= wip_d;
      wel_q   <= wel_d;
      start_q <= accept;
      if (sr_write) begin
        bp_q   <= bp_new;
        srwd_q <= srwd_new;
      end
      if (snap_en) snap_q <= status_now;
      if (accept) begin
        kind_q <= kind;
        addr_q <= addr;
      end
    end
  end

  AST_WEL_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(cmd_valid && cmd_op == OPC_WREN)) else $error("latch set without 06h"); // R2
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> ($past(wel_q) && wel_q)) else $error("start without latch"); // R3
  AST_SR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (srwd_q && !wp_n) |=> ($stable(bp_q) && srwd_q)) else $error("locked status changed"); // R4
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (!$past(wip_q) && wip_q)) else $error("start while busy"); // R5
  AST_CHIP_BP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && kind_q == 3'd4) |-> (bp_q == 3'd0)) else $error("chip erase with protection"); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && wip_q) |=> (!wip_q && !wel_q)) else $error("done did not clear"); // R10
endmodule

// File: rtl/flash_wr_ctrl.sv
`timescale 1ns/1ps
module flash_wr_ctrl
  import flash_wr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  input  logic              cs_rise,
  input  logic [2:0]        bit_rem,
  input  logic              wp_n,
  input  logic              op_done,
  output logic              op_start,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic              wip,
  output logic [7:0]        status_out
);
  logic [7:0]        op_q;
  logic [CNT_W-1:0]  nbytes;
  logic [ADDR_W-1:0] addr;
  logic              srwd_new;
  logic [2:0]        bp_new;
  logic              wel, srwd;
  logic [2:0]        bp;
  logic              accept, sr_write;
  wr_kind_e          kind;

  wrc_cmd_track #(.ADDR_W(ADDR_W)) i_track (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .byte_valid(byte_valid), .byte_in(byte_in), .cs_rise(cs_rise), .busy(wip),
    .op_q(op_q), .nbytes_q(nbytes), .addr_q(addr),
    .srwd_new_q(srwd_new), .bp_new_q(bp_new)
  );

  wrc_gate i_gate (
    .cs_rise(cs_rise), .bit_rem(bit_rem), .op(op_q), .nbytes(nbytes),
    .addr_top(addr[ADDR_W-1 -: 2]), .wp_n(wp_n), .wel(wel), .wip(wip),
    .bp(bp), .srwd(srwd), .accept(accept), .sr_write(sr_write), .kind(kind)
  );

  wrc_status #(.ADDR_W(ADDR_W)) i_status (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .byte_valid(byte_valid), .op_q(op_q), .wp_n(wp_n), .accept(accept),
    .sr_write(sr_write), .kind(kind), .srwd_new(srwd_new), .bp_new(bp_new),
    .addr(addr), .op_done(op_done), .wip_q(wip), .wel_q(wel), .bp_q(bp),
    .srwd_q(srwd), .snap_q(status_out), .start_q(op_start),
    .kind_q(op_kind), .addr_q(op_addr)
  );

  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(cs_rise && bit_rem == 3'd0)) else $error("start off a byte boundary"); // R6
  AST_START_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start) else $error("start longer than one cycle"); // R7
endmodule

// File: tb/test_flash_wr_ctrl.sv
`timescale 1ns/1ps
module test_flash_wr_ctrl;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_op = 8'h00;
  logic          byte_valid = 1'b0;
  logic [7:0]    byte_in = 8'h00;
  logic          cs_rise = 1'b0;
  logic [2:0]    bit_rem = 3'd0;
  logic          wp_n = 1'b1;
  logic          op_done = 1'b0;
  logic          op_start;
  logic [2:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic          wip;
  logic [7:0]    status_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic       m_wip = 1'b0, m_wel = 1'b0, m_srwd = 1'b0;
  logic [2:0] m_bp = 3'd0;

  always #10 clk = ~clk;

  flash_wr_ctrl #(.ADDR_W(AW)) i_flash_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .byte_valid(byte_valid), .byte_in(byte_in), .cs_rise(cs_rise),
    .bit_rem(bit_rem), .wp_n(wp_n), .op_done(op_done), .op_start(op_start),
    .op_kind(op_kind), .op_addr(op_addr), .wip(wip), .status_out(status_out)
  );

  function automatic logic [7:0] m_status();
    return {m_srwd, 2'b00, m_bp, m_wel, m_wip};
  endfunction

  function automatic logic m_locked(input logic [2:0] bp, input logic [1:0] top);
    if (bp[2] || bp[1:0] == 2'd3) return 1'b1;
    if (bp[1:0] == 2'd1) return top == 2'b11;
    if (bp[1:0] == 2'd2) return top[1];
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic done_pulse();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    if (m_wip) begin
      m_wip = 1'b0;
      m_wel = 1'b0;
    end
  endtask

  // bytes[31:24] is the first byte after the opcode; later bytes reuse bytes[7:0]
  task automatic issue(input logic [7:0] op, input int nb, input logic [31:0] bytes,
                       input logic [2:0] rem, input string tag);
    logic       ign, acc;
    int         cnt, kind;
    logic [AW-1:0] addr;
    ign = m_wip && (op != 8'h05);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!m_wip) begin
      if (op == 8'h06) m_wel = 1'b1;
      if (op == 8'h04) m_wel = 1'b0;
    end
    if (op == 8'h05) chk("R11 status at opcode", status_out, m_status());
    for (int i = 0; i < nb; i++) begin
      byte_valid = 1'b1;
      byte_in = (i < 4) ? bytes[31-8*i -: 8] : bytes[7:0];
      @(negedge clk);
      byte_valid = 1'b0;
      if (op == 8'h05) chk("R11 status per byte", status_out, m_status());
    end
    cs_rise = 1'b1; bit_rem = rem;
    @(negedge clk);
    cs_rise = 1'b0; bit_rem = 3'd0;
    cnt  = (nb + 1 > 5) ? 5 : nb + 1;
    addr = bytes[8+AW-1:8];
    acc  = 1'b0;
    kind = 0;
    if (!ign && !m_wip && m_wel && rem == 3'd0) begin
      case (op)
        8'h01: begin kind = 0; acc = (cnt >= 2) && !(m_srwd && !wp_n); end
        8'h02: begin kind = 1; acc = (cnt >= 5) && !m_locked(m_bp, addr[AW-1 -: 2]); end
        8'h20, 8'hD7: begin kind = 2; acc = (cnt >= 4) && !m_locked(m_bp, addr[AW-1 -: 2]); end
        8'hD8: begin kind = 3; acc = (cnt >= 4) && !m_locked(m_bp, addr[AW-1 -: 2]); end
        8'hC7, 8'h60: begin kind = 4; acc = (m_bp == 3'd0); end
        default: acc = 1'b0;
      endcase
    end
    chk({tag, " start"}, op_start, acc);
    if (acc) begin
      chk("R7 kind", op_kind, kind);
      if (kind >= 1 && kind <= 3) chk("R9 address", op_addr, addr);
      m_wip = 1'b1;
      if (kind == 0) begin
        m_srwd = bytes[31];
        m_bp   = bytes[28:26];
      end
    end
  endtask

  task automatic read_status(input string tag);
    issue(8'h05, 0, 32'h0, 3'd0, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [12];
    int unused_seed;
    ops = '{8'h06, 8'h06, 8'h04, 8'h05, 8'h01, 8'h02, 8'h20, 8'hD7, 8'hD8, 8'hC7, 8'h60, 8'h9F};
    unused_seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wip", wip, 0);
    chk("R1 start", op_start, 0);
    chk("R1 status", status_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    read_status("R1 read");
    // R3 no latch
    issue(8'h02, 4, 32'h0000_0055, 3'd0, "R3 prog without latch");
    issue(8'h01, 1, 32'h1C00_0000, 3'd0, "R3 wrsr without latch");
    // R2 latch set/clear and layout
    issue(8'h06, 0, 32'h0, 3'd0, "R2 wren");
    read_status("R2 read");
    chk("R2 latch bit", status_out, 8'h02);
    issue(8'h04, 0, 32'h0, 3'd0, "R2 wrdi");
    read_status("R2 read");
    chk("R2 cleared", status_out, 8'h00);
    issue(8'h06, 0, 32'h0, 3'd0, "R2 wren");
    // R6 ragged clock count
    issue(8'h01, 1, 32'hFF00_0000, 3'd3, "R6 ragged wrsr");
    // R7 too short
    issue(8'h01, 0, 32'h0, 3'd0, "R7 short wrsr");
    // R4 write status: all ones
    issue(8'h01, 1, 32'hFF00_0000, 3'd0, "R4 wrsr");
    read_status("R4 read");
    chk("R4 layout", status_out, 8'h9F);
    // R5 busy lockout
    issue(8'h04, 0, 32'h0, 3'd0, "R5 wrdi busy");
    issue(8'h02, 4, 32'h0000_0011, 3'd0, "R5 prog busy");
    read_status("R5 read");
    chk("R5 unchanged", status_out, 8'h9F);
    // R11 long status read with done in the middle
    cmd_valid = 1'b1; cmd_op = 8'h05;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 opcode snap", status_out, 8'h9F);
    done_pulse();
    chk("R11 no refresh before byte", status_out, 8'h9F);
    byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
    chk("R11 refreshed", status_out, 8'h9C);
    cs_rise = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
    // R10
    chk("R10 wip clear", wip, 0);
    // R4 lock with wp_n low
    wp_n = 1'b0;
    issue(8'h06, 0, 32'h0, 3'd0, "R4 wren");
    issue(8'h01, 1, 32'h0000_0000, 3'd0, "R4 locked wrsr");
    read_status("R4 read");
    chk("R4 locked", status_out, 8'h9E);
    wp_n = 1'b1;
    issue(8'h01, 1, 32'h0400_0000, 3'd0, "R4 unlocked wrsr");
    done_pulse();
    // R8 chip erase vs protection (bp=001)
    issue(8'h06, 0, 32'h0, 3'd0, "R8 wren");
    issue(8'hC7, 0, 32'h0, 3'd0, "R8 chip protected");
    // R9 top quarter protected
    issue(8'h02, 4, 32'h0300_00AA, 3'd0, "R9 prog locked");
    issue(8'hD8, 3, 32'h0200_0000, 3'd0, "R9 block open");
    chk("R9 addr", op_addr, 18'h20000);
    done_pulse();
    issue(8'h06, 0, 32'h0, 3'd0, "R8 wren");
    issue(8'h01, 1, 32'h0000_0000, 3'd0, "R8 clear bp");
    done_pulse();
    issue(8'h06, 0, 32'h0, 3'd0, "R8 wren");
    issue(8'h60, 0, 32'h0, 3'd0, "R8 chip open");
    chk("R7 chip kind", op_kind, 4);
    done_pulse();
    issue(8'h06, 0, 32'h0, 3'd0, "R7 wren");
    issue(8'h20, 2, 32'h0100_0000, 3'd0, "R7 short sector");
    issue(8'hD7, 3, 32'h0112_3400, 3'd0, "R7 sector");
    done_pulse();
    // random phase
    for (int it = 0; it < 600; it++) begin
      int  pick, nb;
      logic [2:0] rem;
      if (m_wip && ($urandom % 2 == 0)) done_pulse();
      if ($urandom % 8 == 0) wp_n = ~wp_n;
      pick = $urandom % 12;
      nb   = $urandom % 7;
      rem  = ($urandom % 5 == 0) ? 3'($urandom % 8) : 3'd0;
      if (ops[pick] == 8'h01) issue(ops[pick], nb, {$urandom} & 32'h7FFF_FFFF, rem, "R4 rand");
      else issue(ops[pick], nb, $urandom, rem, "R9 rand");
      read_status("R2 rand read");
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule